// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block gathers the completion event and the error events of one DMA channel into a sticky status register. It ANDs that register with a software-written enable register and drives a single level-sensitive interrupt line. The transfer and event engines deliver single-cycle pulses on a six-bit source input. Software reads the pending bits, writes ones to a clear register to acknowledge them, and programs the enable mask and an interrupt-mode field through a simple register port. The register port has a write strobe and a combinational read of whatever address is presented.

The six sources sit at fixed, sparse bit positions: one completion bit and five error bits. A channel reset that finishes may raise status bits like any other event. Software then acknowledges them through the clear register. The line stays up as long as any enabled pending bit is set. An event that software has not yet handled therefore keeps requesting service.

The line is driven by a two-state machine. `LINE_IDLE` moves to `LINE_ACTIVE` on the *raise* transition, which fires when the masked cause is non-zero and the mode field selects plain IRQ. `LINE_ACTIVE` returns to `LINE_IDLE` on the *drop* transition, which fires when the masked cause is zero or the mode field selects anything else.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, status, enable and mode all read as zero and `irq_out` is low.
- R2: The `src_evt` bits map to status bit positions as follows: bit 0 to bit 0 (end-of-block completion), bit 1 to bit 1 (event write-response error), bit 2 to bit 9 (descriptor read-response error), bit 3 to bit 10 (data read error), bit 4 to bit 11 (data write error) and bit 5 to bit 14 (invalid descriptor). A pulse sets its bit at the next clock edge. The full valid mask is 0x4E03.
- R3: Status bits stay set until they are cleared, including while their enable bit is zero. Enabling a bit later exposes an old pending event.
- R4: A write to offset 0x108 clears every status bit whose data bit is one. Data bits that are zero leave their status bit unchanged. Offset 0x108 reads as zero.
- R5: If a source pulse and a clear of the same bit land in the same cycle, the bit stays set.
- R6: The enable register at offset 0x110 is read/write on the valid bits. The status register reads at offset 0x100.
- R7: `irq_out` rises one cycle after (status AND enable) becomes non-zero while the mode is 1. It stays high while that cause is non-zero and falls one cycle after the cause becomes zero.
- R8: Bits [3:0] of offset 0x004 hold the interrupt mode. Value 1 selects plain IRQ. Any other value holds `irq_out` low from the next cycle on.
- R9: Bits outside the valid mask read as zero and ignore writes. Writes to the status offset have no effect. Unmapped offsets read as zero. Mode bits above [3:0] read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 6 | Single-cycle event pulses from the engines |
| bus_addr | input | 12 | Register byte offset |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Level interrupt line |

## Verification
The bench pulses each source on its own and reads back the status register. A wrong entry in the sparse bit map would therefore show up as a bit at the wrong position. It latches an error while that error is disabled and only then enables it. A design that gated the status update by enable would never raise the line at that point. It fires a source pulse in the same cycle as a clear of that bit. Clear-wins priority would leave the bit at zero. It samples the line both in the cycle right after the enable or clear write and one cycle later. This catches a design that is one cycle early or late, or that keeps the line high once the mode field leaves plain IRQ.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    localparam int REG_W  = 32;
    localparam int NSRC   = 6;
    localparam int MODE_W = 4;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;

    // Status bit position that each source pulse sets.
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 9;
            3:       return 10;
            4:       return 11;
            default: return 14;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] valid_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) m[src_pos(i)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/dirq_src_map.sv
module dirq_src_map
    import dirq_pkg::*;
(
    input  logic [NSRC-1:0]  src_evt,
    output logic [REG_W-1:0] set_vec
);
    logic [REG_W-1:0] one_hot [NSRC];

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            localparam int POS = src_pos(g);
            always_comb begin
                one_hot[g]      = '0;
                one_hot[g][POS] = src_evt[g];
            end
        end
    endgenerate

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NSRC; i++) set_vec = set_vec | one_hot[i];
    end
endmodule

// File: rtl/dirq_regs.sv
module dirq_regs
    import dirq_pkg::*;
#(
    parameter int ADDR_W          = 12,
    parameter logic [11:0] OFS_MODE = 12'h004,
    parameter logic [11:0] OFS_STAT = 12'h100,
    parameter logic [11:0] OFS_CLR  = 12'h108,
    parameter logic [11:0] OFS_EN   = 12'h110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  set_vec,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [REG_W-1:0]  cause,
    output logic [MODE_W-1:0] mode
);
    localparam logic [REG_W-1:0] VALID = valid_mask();

    logic [REG_W-1:0]  status_q, status_d;
    logic [REG_W-1:0]  enable_q, enable_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic              wr_clr, wr_en, wr_mode;
    logic [REG_W-1:0]  clr_mask;

    always_comb begin
        wr_clr   = bus_wen && (bus_addr == ADDR_W'(OFS_CLR));
        wr_en    = bus_wen && (bus_addr == ADDR_W'(OFS_EN));
        wr_mode  = bus_wen && (bus_addr == ADDR_W'(OFS_MODE));
        clr_mask = wr_clr ? (bus_wdata & VALID) : '0;
        // a new event outranks a clear of the same bit
        status_d = (status_q & ~clr_mask) | (set_vec & VALID);
        enable_d = wr_en ? (bus_wdata & VALID) : enable_q;
        mode_d   = wr_mode ? bus_wdata[MODE_W-1:0] : mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            mode_q   <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
            mode_q   <= mode_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STAT))      bus_rdata = status_q;
        else if (bus_addr == ADDR_W'(OFS_EN))   bus_rdata = enable_q;
        else if (bus_addr == ADDR_W'(OFS_MODE)) bus_rdata = REG_W'(mode_q);
    end

    assign cause = status_q & enable_q;
    assign mode  = mode_q;

    // R3: without a clear write, no pending bit is lost
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4: bits written as one with no competing event end up cleared
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((status_q & $past(bus_wdata & ~set_vec)) == '0));

    // R5: an event always lands, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R6: enable only changes on a write to its offset
    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable_q));

    // R9: reserved bits never become visible
    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | enable_q) & ~VALID) == '0);
endmodule

// File: rtl/dirq_line_fsm.sv
module dirq_line_fsm
    import dirq_pkg::*;
#(
    parameter logic [MODE_W-1:0] MODE_IRQ = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  cause,
    input  logic [MODE_W-1:0] mode,
    output logic              irq_out
);
    line_state_e state_q, state_d;
    logic        want;

    assign want = (cause != '0) && (mode == MODE_IRQ);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (want)  state_d = LINE_ACTIVE;  // raise
            LINE_ACTIVE: if (!want) state_d = LINE_IDLE;    // drop
            default:     state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb irq_out = (state_q == LINE_ACTIVE);

    // R7: an enabled pending cause in IRQ mode raises the line next cycle
    p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause != '0) && (mode == MODE_IRQ)) |=> irq_out);

    // R7: no cause, no line
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause == '0) |=> !irq_out);

    // R8: any other mode keeps the line low
    p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_IRQ) |=> !irq_out);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_out
);
    logic [REG_W-1:0]  set_vec;
    logic [REG_W-1:0]  cause;
    logic [MODE_W-1:0] mode;

    dirq_src_map u_map (
        .src_evt (src_evt),
        .set_vec (set_vec)
    );

    dirq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cause     (cause),
        .mode      (mode)
    );

    dirq_line_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause   (cause),
        .mode    (mode),
        .irq_out (irq_out)
    );
endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
    localparam logic [11:0] A_MODE = 12'h004;
    localparam logic [11:0] A_STAT = 12'h100;
    localparam logic [11:0] A_CLR  = 12'h108;
    localparam logic [11:0] A_EN   = 12'h110;
    localparam logic [31:0] ALL    = 32'h0000_4E03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_evt = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    always #2 clk = ~clk;

    dma_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // status bit for each source, as stated in R2
    function automatic logic [31:0] pos_bit(input int i);
        int p [6] = '{0, 1, 9, 10, 11, 14};
        return 32'h1 << p[i];
    endfunction

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        tick();
        bus_wen = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] m);
        src_evt = m;
        tick();
        src_evt = '0;
    endtask

    task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = t;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = t;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_rd(A_STAT, 32'h0, "R1 status");
        chk_rd(A_EN,   32'h0, "R1 enable");
        chk_rd(A_MODE, 32'h0, "R1 mode");
        chk_irq(1'b0, "R1 irq");

        // R2 + R3: all sources latch while disabled
        pulse(6'h3F);
        chk_rd(A_STAT, ALL, "R2 all sources");
        chk_irq(1'b0, "R3 disabled no irq");
        wr(A_CLR, ALL);
        chk_rd(A_STAT, 32'h0, "R4 clear all");

        // R2 per-source bit map
        for (int i = 0; i < 6; i++) begin
            pulse(6'h1 << i);
            chk_rd(A_STAT, pos_bit(i), $sformatf("R2 source %0d", i));
            wr(A_CLR, pos_bit(i));
            chk_rd(A_STAT, 32'h0, $sformatf("R4 clear source %0d", i));
        end

        // R6 / R8 / R9 register access
        wr(A_EN, 32'hFFFF_FFFF);
        chk_rd(A_EN, ALL, "R6 R9 enable valid bits");
        wr(A_MODE, 32'h37);
        chk_rd(A_MODE, 32'h7, "R8 mode low nibble");
        wr(A_STAT, 32'hFFFF_FFFF);
        chk_rd(A_STAT, 32'h0, "R9 status not writable");
        chk_rd(A_CLR, 32'h0, "R4 clear reads zero");
        chk_rd(12'h200, 32'h0, "R9 unmapped");
        chk_irq(1'b0, "R8 no cause");

        // R3: old pending event revealed by enabling it
        wr(A_EN, 32'h1);
        wr(A_MODE, 32'h1);
        pulse(6'h02);
        tick();
        chk_irq(1'b0, "R7 masked bit gives no irq");
        wr(A_EN, 32'h2);
        chk_irq(1'b0, "R7 one cycle latency");
        chk_irq(1'b1, "R3 old event raises irq");

        // R4: zero write has no effect
        wr(A_CLR, 32'h0);
        chk_rd(A_STAT, 32'h2, "R4 zeros no effect");
        chk_irq(1'b1, "R7 line held");

        // R7 drop timing
        pulse(6'h01);
        wr(A_CLR, 32'h2);
        chk_irq(1'b1, "R7 drop one cycle later");
        chk_irq(1'b0, "R7 dropped");
        chk_rd(A_STAT, 32'h1, "R4 only bit1 cleared");

        // R8 mode gating
        wr(A_EN, ALL);
        chk_irq(1'b0, "R7 still one cycle");
        chk_irq(1'b1, "R7 raised on bit0");
        wr(A_MODE, 32'h2);
        chk_irq(1'b1, "R8 still active one cycle");
        chk_irq(1'b0, "R8 mode 2 line low");
        wr(A_MODE, 32'h1);
        chk_irq(1'b0, "R8 mode back, one cycle");
        chk_irq(1'b1, "R8 mode 1 line high");

        // R5 set wins over same-cycle clear
        pulse(6'h20);
        chk_rd(A_STAT, 32'h4001, "R2 bit14 set");
        src_evt = 6'h01; bus_addr = A_CLR; bus_wdata = 32'h4001; bus_wen = 1'b1;
        tick();
        src_evt = '0; bus_wen = 1'b0;
        chk_rd(A_STAT, 32'h1, "R5 set wins");

        // final clear, line drops
        wr(A_CLR, ALL);
        chk_irq(1'b1, "R7 final hold");
        chk_irq(1'b0, "R7 final drop");
        chk_rd(A_STAT, 32'h0, "R4 final clear");

        tick();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule